// File: doc/BRIEF.md
# Shared-Pin GPIO Port Controller

This block holds the configuration and data registers for eight pads that are shared between general-purpose I/O and capacitive sensing electrodes, and turns them into per-pad drive controls. Software reaches the registers through a byte-wide write/read port with an 8-bit address. Port bit 7 down to bit 0 serves electrode pads 11 down to 4. Each register holds one bit per port in that order.

A separate configuration source supplies the electrode count. In run mode, any pad that the count claims becomes an electrode, and its GPIO controls are forced off whatever the enable register says. Output level changes are staged: in run mode they reach the pads only on the cycle after an ADC conversion-done strobe, so a pad never switches while electrodes are charging. In stop mode they pass through after one cycle. Pad inputs pass through a two-flop synchronizer and are then latched. The data register view returns latched levels for input ports and stored bits for everything else.

Top module: `gpio_share_ctl`

## Requirements
- R1: After reset, every pad control output (output enable, level, pull-up, pull-down, open-drain-high, open-drain-low) is 0, and the control, direction, enable and data registers read 0.
- R2: The register map is as follows:
  - 0x73: control-0 bits.
  - 0x74: control-1 bits.
  - 0x75: data.
  - 0x76: direction (1 = output).
  - 0x77: enable.
  - 0x78: set.
  - 0x79: clear.
  - 0x7A: toggle.

  Register bit i controls port i. Control, direction and enable read back as written. Addresses outside 0x73..0x7A read 0.
- R3: A port whose enable bit is 0 has every pad control output at 0, whatever its control and direction bits hold.
- R4: An enabled input port (direction 0) never drives its pad. Its pulls follow the control pair as control-0:control-1:
  - 1:0 gives a pull-down.
  - 1:1 gives a pull-up.
  - 0:0 and 0:1 give no pull.
- R5: An enabled output port (direction 1) sets level = the applied data bit. Its drive follows the control pair:
  - 0:0 and 0:1 give push-pull, with output enable 1.
  - 1:1 gives high-side open drain: open-drain-high = 1, and output enable = level.
  - 1:0 gives low-side open drain: open-drain-low = 1, and output enable = inverted level.
- R6: In run mode, port i is an electrode when the electrode count exceeds i+4, and all its pad controls are then 0. In stop mode the count has no effect.
- R7: Writing the set, clear or toggle address sets, clears or inverts exactly those data bits written as 1. Bits written as 0 are unchanged.
- R8: Reading 0x78, 0x79 or 0x7A returns the same value as reading 0x75.
- R9: The 0x75 view returns the latched pad level for enabled input ports and the stored data bit for all other ports. A pad change appears in the view three clocks later. Writing data leaves the view of input ports unchanged but updates their stored bit.
- R10: In run mode, a change in stored data reaches the pad level only in the cycle after a conversion-done strobe. In stop mode it reaches the pad one cycle after the data register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Register address for write and read |
| wrData | input | 8 | Write data |
| wrEn | input | 1 | Write strobe, one cycle per write |
| rdData | output | 8 | Read data for regAddr (combinational) |
| runMode | input | 1 | 1 = run mode, 0 = stop mode |
| convDone | input | 1 | ADC conversion-done strobe |
| electrodeCount | input | 4 | Number of electrodes in use (0..12) |
| padIn | input | 8 | Pad input levels |
| padOe | output | 8 | Pad output enable |
| padOut | output | 8 | Pad output level |
| padPullUp | output | 8 | Pull-up enable |
| padPullDown | output | 8 | Pull-down enable |
| padOdHigh | output | 8 | High-side-only open-drain mode |
| padOdLow | output | 8 | Low-side-only open-drain mode |

## Verification
The assertions assume the following about the inputs:
- electrodeCount stays within 0..12.
- convDone is a strobe.
- A write asserts wrEn for one cycle with the address and data held steady around the edge.

Under those assumptions they check the disabled and electrode-owned pads, the absence of pulls on outputs, the held level between conversions, and the set/clear masks. The stimulus changes every input on the falling clock edge, and it pulses convDone for exactly one cycle. It sweeps the count only across in-range values, including the boundary value 4 and the full value 12.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CTL0,
    RD_CTL1,
    RD_DATA,
    RD_DIR,
    RD_EN
  } rdSel_t;

  // Strobes from the decode side to the register side
  typedef struct packed {
    logic   wrCtl0;
    logic   wrCtl1;
    logic   wrData;
    logic   wrDir;
    logic   wrEn;
    logic   wrSet;
    logic   wrClr;
    logic   wrTog;
    logic   applyOut;
    rdSel_t rdSel;
  } gpioStrobe_t;

endpackage

// File: rtl/gpio_share_ctrl.sv
module gpio_share_ctrl
  import gpio_share_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h73
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              runMode,
  input  logic              convDone,
  output gpioStrobe_t       strb
);

  localparam int SPAN = 8;

  logic [ADDR_W-1:0] offs;
  logic              hit;

  assign offs = regAddr - BASE_ADDR;
  assign hit  = (regAddr >= BASE_ADDR) && (int'(offs) < SPAN);

  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    // Staged levels move to the pads on a conversion, or freely in stop mode
    strb.applyOut = convDone | ~runMode;
    if (hit) begin
      unique case (int'(offs))
        0: begin strb.rdSel = RD_CTL0; strb.wrCtl0 = wrEn; end
        1: begin strb.rdSel = RD_CTL1; strb.wrCtl1 = wrEn; end
        2: begin strb.rdSel = RD_DATA; strb.wrData = wrEn; end
        3: begin strb.rdSel = RD_DIR;  strb.wrDir  = wrEn; end
        4: begin strb.rdSel = RD_EN;   strb.wrEn   = wrEn; end
        5: begin strb.rdSel = RD_DATA; strb.wrSet  = wrEn; end
        6: begin strb.rdSel = RD_DATA; strb.wrClr  = wrEn; end
        7: begin strb.rdSel = RD_DATA; strb.wrTog  = wrEn; end
        default: strb.rdSel = RD_NONE;
      endcase
    end
  end

  AST_ONE_REG_PER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrCtl0, strb.wrCtl1, strb.wrData, strb.wrDir,
              strb.wrEn, strb.wrSet, strb.wrClr, strb.wrTog})); // R2

  AST_NO_WRITE_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(strb.wrData | strb.wrSet | strb.wrClr | strb.wrTog)); // R7

endmodule

// File: rtl/gpio_share_dp.sv
module gpio_share_dp
  import gpio_share_pkg::*;
#(
  parameter int PORTS      = 8,
  parameter int CNT_W      = 4,
  parameter int FIRST_ELEC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  gpioStrobe_t      strb,
  input  logic [PORTS-1:0] wrData,
  input  logic             runMode,
  input  logic             convDone,
  input  logic [CNT_W-1:0] electrodeCount,
  input  logic [PORTS-1:0] padIn,
  output logic [PORTS-1:0] rdData,
  output logic [PORTS-1:0] padOe,
  output logic [PORTS-1:0] padOut,
  output logic [PORTS-1:0] padPullUp,
  output logic [PORTS-1:0] padPullDown,
  output logic [PORTS-1:0] padOdHigh,
  output logic [PORTS-1:0] padOdLow
);

  logic [PORTS-1:0] ctl0R, ctl1R, dirR, enR, dataR;
  logic [PORTS-1:0] driveLvl;
  logic [PORTS-1:0] syncA, syncB, inLatch;
  logic [PORTS-1:0] inMode, outMode;
  logic [PORTS-1:0] dataView;

  // Register file and staged output level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl0R    <= '0;
      ctl1R    <= '0;
      dirR     <= '0;
      enR      <= '0;
      dataR    <= '0;
      driveLvl <= '0;
    end else begin
      if (strb.wrCtl0) ctl0R <= wrData;
      if (strb.wrCtl1) ctl1R <= wrData;
      if (strb.wrDir)  dirR  <= wrData;
      if (strb.wrEn)   enR   <= wrData;
      if (strb.wrData)     dataR <= wrData;
      else if (strb.wrSet) dataR <= dataR | wrData;
      else if (strb.wrClr) dataR <= dataR & ~wrData;
      else if (strb.wrTog) dataR <= dataR ^ wrData;
      if (strb.applyOut) driveLvl <= dataR;
    end
  end

  // Pad input: two synchronizing flops, then a latch held while not an input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      inLatch <= '0;
    end else begin
      syncA <= padIn;
      syncB <= syncA;
      for (int b = 0; b < PORTS; b++) begin
        if (inMode[b]) inLatch[b] <= syncB[b];
      end
    end
  end

  for (genvar i = 0; i < PORTS; i++) begin : gPin
    logic elecSel, active, odH, odL;

    assign elecSel = int'(electrodeCount) > (FIRST_ELEC + i);
    assign active  = enR[i] & ~(runMode & elecSel);
    assign inMode[i]  = active & ~dirR[i];
    assign outMode[i] = active & dirR[i];
    assign odH = outMode[i] & ctl0R[i] & ctl1R[i];
    assign odL = outMode[i] & ctl0R[i] & ~ctl1R[i];

    assign padPullUp[i]   = inMode[i] & ctl0R[i] & ctl1R[i];
    assign padPullDown[i] = inMode[i] & ctl0R[i] & ~ctl1R[i];
    assign padOdHigh[i]   = odH;
    assign padOdLow[i]    = odL;
    assign padOut[i]      = outMode[i] & driveLvl[i];
    assign padOe[i]       = outMode[i] & (odH ? driveLvl[i] :
                                          odL ? ~driveLvl[i] : 1'b1);

    AST_DISABLED_PAD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
      !enR[i] |-> !(padOe[i] | padOut[i] | padPullUp[i] | padPullDown[i] |
                    padOdHigh[i] | padOdLow[i])); // R3

    AST_ELECTRODE_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (runMode && (int'(electrodeCount) > FIRST_ELEC + i)) |->
        !(padOe[i] | padPullUp[i] | padPullDown[i] | padOdHigh[i] | padOdLow[i])); // R6

    AST_NO_PULL_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rstN)
      dirR[i] |-> !(padPullUp[i] | padPullDown[i])); // R4

    AST_INPUT_NEVER_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
      !dirR[i] |-> !(padOe[i] | padOdHigh[i] | padOdLow[i])); // R4

    AST_OD_HIGH_ONLY_SOURCES: assert property (@(posedge clk) disable iff (!rstN)
      (padOdHigh[i] && padOe[i]) |-> padOut[i]); // R5

    AST_OD_LOW_ONLY_SINKS: assert property (@(posedge clk) disable iff (!rstN)
      (padOdLow[i] && padOe[i]) |-> !padOut[i]); // R5
  end

  assign dataView = (dataR & ~inMode) | (inLatch & inMode);

  always_comb begin
    unique case (strb.rdSel)
      RD_CTL0: rdData = ctl0R;
      RD_CTL1: rdData = ctl1R;
      RD_DATA: rdData = dataView;
      RD_DIR:  rdData = dirR;
      RD_EN:   rdData = enR;
      default: rdData = '0;
    endcase
  end

  AST_HOLD_BETWEEN_CONVERSIONS: assert property (@(posedge clk) disable iff (!rstN)
    (runMode && !convDone) |=> $stable(driveLvl)); // R10

  AST_SET_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSet |=> ((dataR & $past(wrData)) == $past(wrData))); // R7

  AST_CLR_MASK: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((dataR & $past(wrData)) == '0)); // R7

  AST_TOG_KEEPS_ZEROS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTog |=> ((dataR & ~$past(wrData)) == ($past(dataR) & ~$past(wrData)))); // R7

endmodule

// File: rtl/gpio_share_ctl.sv
module gpio_share_ctl
  import gpio_share_pkg::*;
#(
  parameter int PORTS      = 8,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 4,
  parameter int FIRST_ELEC = 4,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h73
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [PORTS-1:0]  wrData,
  input  logic              wrEn,
  output logic [PORTS-1:0]  rdData,
  input  logic              runMode,
  input  logic              convDone,
  input  logic [CNT_W-1:0]  electrodeCount,
  input  logic [PORTS-1:0]  padIn,
  output logic [PORTS-1:0]  padOe,
  output logic [PORTS-1:0]  padOut,
  output logic [PORTS-1:0]  padPullUp,
  output logic [PORTS-1:0]  padPullDown,
  output logic [PORTS-1:0]  padOdHigh,
  output logic [PORTS-1:0]  padOdLow
);

  gpioStrobe_t strb;

  gpio_share_ctrl #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn),
    .runMode(runMode), .convDone(convDone), .strb(strb)
  );

  gpio_share_dp #(
    .PORTS(PORTS), .CNT_W(CNT_W), .FIRST_ELEC(FIRST_ELEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .runMode(runMode), .convDone(convDone), .electrodeCount(electrodeCount),
    .padIn(padIn), .rdData(rdData), .padOe(padOe), .padOut(padOut),
    .padPullUp(padPullUp), .padPullDown(padPullDown),
    .padOdHigh(padOdHigh), .padOdLow(padOdLow)
  );

endmodule

// File: tb/gpio_share_ctl_bench.sv
module gpio_share_ctl_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] regAddr = '0, wrData = '0, padIn = '0;
  logic       wrEn = 1'b0, runMode = 1'b0, convDone = 1'b0;
  logic [3:0] electrodeCount = '0;
  logic [7:0] rdData, padOe, padOut, padPullUp, padPullDown, padOdHigh, padOdLow;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  localparam int S_RD = 0, S_OE = 1, S_OUT = 2, S_PU = 3, S_PD = 4, S_ODH = 5, S_ODL = 6;

  typedef struct {
    int         sel;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];

  always #5 clk = ~clk;

  gpio_share_ctl u_gpio_share_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrData(wrData), .wrEn(wrEn),
    .rdData(rdData), .runMode(runMode), .convDone(convDone),
    .electrodeCount(electrodeCount), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .padPullUp(padPullUp), .padPullDown(padPullDown),
    .padOdHigh(padOdHigh), .padOdLow(padOdLow)
  );

  function automatic logic [7:0] pick(int sel);
    case (sel)
      S_RD:  return rdData;
      S_OE:  return padOe;
      S_OUT: return padOut;
      S_PU:  return padPullUp;
      S_PD:  return padPullDown;
      S_ODH: return padOdHigh;
      default: return padOdLow;
    endcase
  endfunction

  // Monitor: compares queued expectations a little after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbq.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sbq.pop_front();
        act = pick(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expRd(input logic [7:0] a, input logic [7:0] e, input string tag);
    regAddr = a;
    sbq.push_back('{S_RD, e, tag});
    @(negedge clk);
  endtask

  task automatic expPad(input int sel, input logic [7:0] e, input string tag);
    sbq.push_back('{sel, e, tag});
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1: reset state
    for (int s = S_OE; s <= S_ODL; s++) expPad(s, 8'h00, "R1 pads idle after reset");
    expRd(8'h73, 8'h00, "R1 ctl0 reset");
    expRd(8'h75, 8'h00, "R1 data reset");
    expRd(8'h76, 8'h00, "R1 dir reset");
    expRd(8'h77, 8'h00, "R1 enable reset");

    // R2: readback and unmapped addresses
    wr(8'h73, 8'hA5); expRd(8'h73, 8'hA5, "R2 ctl0 readback");
    wr(8'h74, 8'h3C); expRd(8'h74, 8'h3C, "R2 ctl1 readback");
    expRd(8'h72, 8'h00, "R2 below range");
    expRd(8'h7B, 8'h00, "R2 above range");

    // Ports 3..0 inputs (ctl 11,10,01,00), ports 7..4 outputs (ctl 10,11,01,00)
    padIn = 8'h0A;
    wr(8'h73, 8'hCC);
    wr(8'h74, 8'h6A);
    wr(8'h76, 8'hF0);
    wr(8'h75, 8'h50);
    wr(8'h77, 8'hFF);
    tick(1);
    expRd(8'h76, 8'hF0, "R2 dir readback");
    expPad(S_PD, 8'h04, "R4 pull-down on ctl 10");
    expPad(S_PU, 8'h08, "R4 pull-up on ctl 11");
    expPad(S_ODH, 8'h40, "R5 high-side open drain flag");
    expPad(S_ODL, 8'h80, "R5 low-side open drain flag");
    expPad(S_OUT, 8'h50, "R5 level follows data");
    expPad(S_OE, 8'hF0, "R5 enables at data 0x50");
    tick(1);

    // R7: toggle, set, clear
    wr(8'h7A, 8'hC0); tick(1);
    expPad(S_OUT, 8'h90, "R7 toggle");
    expPad(S_OE, 8'h30, "R5 open drain floats at inactive level");
    tick(1);
    wr(8'h78, 8'h20); tick(1);
    expPad(S_OUT, 8'hB0, "R7 set");
    tick(1);
    wr(8'h79, 8'h90); tick(1);
    expPad(S_OUT, 8'h20, "R7 clear");
    expPad(S_OE, 8'hB0, "R5 enables after clear");
    tick(1);

    // R9 / R8: data view mixes latched inputs and stored outputs
    expRd(8'h75, 8'h2A, "R9 mixed data view");
    expRd(8'h78, 8'h2A, "R8 set address reads data");
    expRd(8'h79, 8'h2A, "R8 clear address reads data");
    expRd(8'h7A, 8'h2A, "R8 toggle address reads data");
    wr(8'h75, 8'h25);
    expRd(8'h75, 8'h2A, "R9 data write leaves input view");
    expPad(S_PD, 8'h04, "R9 input behaviour kept");
    wr(8'h76, 8'hFF);
    expRd(8'h75, 8'h25, "R9 stored bits visible as outputs");
    wr(8'h76, 8'hF0);
    padIn = 8'h05;
    tick(2);
    expRd(8'h75, 8'h2A, "R9 pad change not yet visible");
    expRd(8'h75, 8'h25, "R9 pad change after three clocks");

    // R3: disabled outputs go idle
    wr(8'h77, 8'h0F);
    expPad(S_OE, 8'h00, "R3 disabled no drive");
    expPad(S_OUT, 8'h00, "R3 disabled no level");
    expPad(S_ODH, 8'h00, "R3 disabled no od high");
    expPad(S_ODL, 8'h00, "R3 disabled no od low");
    expPad(S_PD, 8'h04, "R3 enabled input untouched");
    tick(1);
    wr(8'h77, 8'hFF);

    // R10: run mode holds level until conversion done
    runMode = 1'b1;
    tick(1);
    wr(8'h75, 8'h50);
    tick(2);
    expPad(S_OUT, 8'h20, "R10 level held in run mode");
    expRd(8'h75, 8'h55, "R10 stored data updates at once");
    convDone = 1'b1;
    @(negedge clk);
    convDone = 1'b0;
    expPad(S_OUT, 8'h50, "R10 level applied after conversion");
    tick(1);

    // R6: electrode override in run mode
    electrodeCount = 4'd10;
    expPad(S_PD, 8'h00, "R6 electrode removes pull-down");
    expPad(S_OE, 8'hC0, "R6 electrode removes drive");
    expPad(S_OUT, 8'h40, "R6 electrode removes level");
    tick(1);
    electrodeCount = 4'd4;
    expPad(S_PD, 8'h04, "R6 count 4 claims no port");
    tick(1);
    electrodeCount = 4'd12;
    expPad(S_OE, 8'h00, "R6 all ports electrodes");
    expPad(S_PU, 8'h00, "R6 all ports no pull-up");
    tick(1);
    runMode = 1'b0;
    expPad(S_PD, 8'h04, "R6 stop mode ignores count");
    expPad(S_OE, 8'hF0, "R6 stop mode drives outputs");
    tick(2);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule